// File: doc/BRIEF.md
# Pin Request and Acknowledge Tracker

This block keeps the request state for every input pin of an interrupt router. It samples the raw pin levels, applies each pin's polarity, and records one request bit per pin. When a pin has to be serviced it raises a single-cycle delivery request that carries the pin index and the vector from that pin's routing entry. Picking a destination and injecting the interrupt are left to downstream logic.

The routing table itself lives outside the block and arrives as flat vectors: mask, trigger mode, polarity and vector for each pin. The block owns the per-pin remote-request flag, which throttles level-triggered pins until an end-of-interrupt notice with a matching vector arrives. A table-write pulse tells the block that an entry was rewritten, so that a pin with a pending request is serviced again under its new settings.

Each cycle the block does one action. A table write takes precedence over an end-of-interrupt, and an end-of-interrupt takes precedence over pin-level changes. Pin changes are worked off one per cycle, lowest index first.

Top module: `pin_req_tracker`

## Requirements
- R1: In the cycle after reset is released, `req_bits`, `remote_bits` and `dlv_valid` are all 0.
- R2: The effective level is `pin_raw[i]` XOR `cfg_pol[i]`. The raw pins are registered first, and a change is acted on at the next clock edge. When the effective level goes to 0, request bit i is cleared.
- R3: When the effective level of an unmasked level-triggered pin (`cfg_level[i]`=1) rises while its remote flag is clear, the block delivers with `dlv_pin`=i and `dlv_vec`=`cfg_vec[i*VEC_W +: VEC_W]`. Request bit i and remote bit i both become 1.
- R4: When a level-triggered pin with its remote flag set rises again, request bit i is set and nothing is delivered.
- R5: When an edge-triggered pin (`cfg_level[i]`=0) rises, it is delivered if unmasked, and its request bit ends at 0 whether or not it is masked.
- R6: A masked pin (`cfg_mask[i]`=1) is never delivered. A masked level-triggered pin keeps request bit 1, and its remote flag does not change.
- R7: `tbl_wr` with an index below NPINS services that pin again if its request bit is set. The pin is delivered if unmasked, and a level pin then sets its remote flag. When `tbl_wr_lo`=1, the remote flag is cleared before this. A write with an index of NPINS or more changes nothing.
- R8: `eoi_valid` selects the lowest-numbered entry whose vector equals `eoi_vec` and clears its remote flag. If that entry is unmasked and its request bit is set, it is delivered again, and its remote flag stays 0 after that delivery. Other entries with the same vector are not touched.
- R9: An end-of-interrupt whose vector matches no entry changes no state and delivers nothing.
- R10: The block performs one action per cycle, in this order of precedence: table write, then end-of-interrupt, then the lowest-indexed pin with an unprocessed level change. At most one delivery is made per cycle, and at most one request bit and one remote bit change per cycle.
- R11: The delivery outputs are registered. `dlv_valid` is high for exactly one cycle per delivery, and when it is high `dlv_pin` < NPINS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NPINS | Raw pin levels |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_pol | input | NPINS | Per-pin polarity, 1 = active low |
| cfg_vec | input | NPINS*VEC_W | Per-pin vector, entry i at bits [i*VEC_W +: VEC_W] |
| tbl_wr | input | 1 | Pulse: a routing entry was rewritten |
| tbl_wr_idx | input | IDX_W | Index of the rewritten entry |
| tbl_wr_lo | input | 1 | The write touched the low half, which clears the remote flag |
| eoi_valid | input | 1 | Pulse: an end-of-interrupt notice is present |
| eoi_vec | input | VEC_W | Vector carried by the notice |
| dlv_valid | output | 1 | Delivery request, one cycle |
| dlv_pin | output | IDX_W | Pin being delivered |
| dlv_vec | output | VEC_W | Vector of the delivered pin |
| req_bits | output | NPINS | Request register |
| remote_bits | output | NPINS | Remote-request flags |

## Verification
The assertions take for granted that the routing inputs change only in a cycle that also carries `tbl_wr`, and that the pulse presents the entry already updated. Under that assumption, the mask and trigger mode registered in the checker describe the entry that the block acted on. The stimulus holds the table steady during reset and otherwise changes an entry only together with a write pulse. Pin and notice inputs change freely, which exercises the precedence between writes, notices and pending pin changes.

// File: rtl/pin_req_pkg.sv
package pin_req_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_EOI   = 2'd2,
    ACT_PIN   = 2'd3
  } act_e;

endpackage

// File: rtl/pin_req_lowest.sv
module pin_req_lowest #(
  parameter int WIDTH = 24,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] vec,
  output logic             found,
  output logic [IW-1:0]    idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/pin_req_vec_match.sv
module pin_req_vec_match #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8
) (
  input  logic [NPINS*VEC_W-1:0] cfg_vec,
  input  logic [VEC_W-1:0]       key,
  output logic [NPINS-1:0]       hit
);

  for (genvar g = 0; g < NPINS; g++) begin : g_cmp
    assign hit[g] = (cfg_vec[g*VEC_W +: VEC_W] == key);
  end

endmodule

// File: rtl/pin_req_sampler.sv
module pin_req_sampler #(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_raw,
  input  logic [NPINS-1:0] cfg_pol,
  input  logic [NPINS-1:0] seen,
  output logic [NPINS-1:0] eff,
  output logic [NPINS-1:0] dirty
);

  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_raw;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_lvl
    assign eff[g]   = pin_q[g] ^ cfg_pol[g];
    assign dirty[g] = eff[g] ^ seen[g];
  end

endmodule

// File: rtl/pin_req_tracker.sv
module pin_req_tracker
  import pin_req_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       pin_raw,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS-1:0]       cfg_level,
  input  logic [NPINS-1:0]       cfg_pol,
  input  logic [NPINS*VEC_W-1:0] cfg_vec,
  input  logic                   tbl_wr,
  input  logic [IDX_W-1:0]       tbl_wr_idx,
  input  logic                   tbl_wr_lo,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vec,
  output logic                   dlv_valid,
  output logic [IDX_W-1:0]       dlv_pin,
  output logic [VEC_W-1:0]       dlv_vec,
  output logic [NPINS-1:0]       req_bits,
  output logic [NPINS-1:0]       remote_bits
);

  logic [NPINS-1:0] irr_q, rem_q, seen_q;
  logic [NPINS-1:0] irr_n, rem_n, seen_n;
  logic [NPINS-1:0] eff, dirty, eoi_hit;
  logic             dirty_any, eoi_any, wr_ok;
  logic [IDX_W-1:0] dirty_idx, eoi_idx, sel;
  act_e             act;
  logic             svc, fire;

  pin_req_sampler #(.NPINS(NPINS)) u_smp (
    .clk     (clk),
    .rst     (rst),
    .pin_raw (pin_raw),
    .cfg_pol (cfg_pol),
    .seen    (seen_q),
    .eff     (eff),
    .dirty   (dirty)
  );

  pin_req_vec_match #(.NPINS(NPINS), .VEC_W(VEC_W)) u_match (
    .cfg_vec (cfg_vec),
    .key     (eoi_vec),
    .hit     (eoi_hit)
  );

  pin_req_lowest #(.WIDTH(NPINS)) u_pick_pin (
    .vec   (dirty),
    .found (dirty_any),
    .idx   (dirty_idx)
  );

  pin_req_lowest #(.WIDTH(NPINS)) u_pick_eoi (
    .vec   (eoi_hit),
    .found (eoi_any),
    .idx   (eoi_idx)
  );

  assign wr_ok = (32'(tbl_wr_idx) < NPINS);

  // Arbitration: write, then end-of-interrupt, then pin changes.
  always_comb begin
    act = ACT_IDLE;
    sel = '0;
    if (tbl_wr) begin
      if (wr_ok) begin
        act = ACT_WRITE;
        sel = tbl_wr_idx;
      end
    end else if (eoi_valid) begin
      if (eoi_any) begin
        act = ACT_EOI;
        sel = eoi_idx;
      end
    end else if (dirty_any) begin
      act = ACT_PIN;
      sel = dirty_idx;
    end
  end

  // State update for the selected pin.
  always_comb begin
    irr_n  = irr_q;
    rem_n  = rem_q;
    seen_n = seen_q;
    svc    = 1'b0;
    fire   = 1'b0;
    case (act)
      ACT_WRITE: begin
        if (tbl_wr_lo) rem_n[sel] = 1'b0;
        svc = irr_q[sel];
      end
      ACT_EOI: begin
        rem_n[sel] = 1'b0;
        fire = !cfg_mask[sel] && irr_q[sel];
      end
      ACT_PIN: begin
        seen_n[sel] = eff[sel];
        if (eff[sel]) begin
          irr_n[sel] = 1'b1;
          svc = (!cfg_level[sel] && !irr_q[sel]) || !rem_q[sel];
        end else begin
          irr_n[sel] = 1'b0;
        end
      end
      default: ;
    endcase
    if (svc) begin
      if (!cfg_mask[sel]) begin
        fire = 1'b1;
        if (cfg_level[sel]) rem_n[sel] = 1'b1;
      end
      if (!cfg_level[sel]) irr_n[sel] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q     <= '0;
      rem_q     <= '0;
      seen_q    <= '0;
      dlv_valid <= 1'b0;
      dlv_pin   <= '0;
      dlv_vec   <= '0;
    end else begin
      irr_q     <= irr_n;
      rem_q     <= rem_n;
      seen_q    <= seen_n;
      dlv_valid <= fire;
      dlv_pin   <= sel;
      dlv_vec   <= cfg_vec[32'(sel)*VEC_W +: VEC_W];
    end
  end

  assign req_bits    = irr_q;
  assign remote_bits = rem_q;

endmodule

// File: rtl/pin_req_tracker_chk.sv
module pin_req_tracker_chk #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] cfg_mask,
  input logic [NPINS-1:0] cfg_level,
  input logic             tbl_wr,
  input logic [IDX_W-1:0] tbl_wr_idx,
  input logic             eoi_valid,
  input logic             dlv_valid,
  input logic [IDX_W-1:0] dlv_pin,
  input logic [NPINS-1:0] req_bits,
  input logic [NPINS-1:0] remote_bits
);

  logic [NPINS-1:0] mask_d, lvl_d;
  logic             bad_wr_d, eoi_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_d   <= '0;
      lvl_d    <= '0;
      bad_wr_d <= 1'b0;
      eoi_d    <= 1'b0;
    end else begin
      mask_d   <= cfg_mask;
      lvl_d    <= cfg_level;
      bad_wr_d <= tbl_wr && (32'(tbl_wr_idx) >= NPINS);
      eoi_d    <= eoi_valid && !tbl_wr;
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_bits == '0 && remote_bits == '0 && !dlv_valid));

  // R11
  pin_range_chk: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (32'(dlv_pin) < NPINS));

  // R6
  masked_no_dlv_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && 32'(dlv_pin) < NPINS) |-> !mask_d[dlv_pin]);

  // R5
  edge_req_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && 32'(dlv_pin) < NPINS && !lvl_d[dlv_pin]) |-> !req_bits[dlv_pin]);

  // R3
  level_remote_set_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && 32'(dlv_pin) < NPINS && lvl_d[dlv_pin] && !eoi_d) |-> remote_bits[dlv_pin]);

  // R7
  bad_write_chk: assert property (@(posedge clk) disable iff (rst)
    bad_wr_d |-> (!dlv_valid && $stable(req_bits) && $stable(remote_bits)));

  // R10
  one_req_change_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(req_bits ^ $past(req_bits)) <= 1);

  // R10
  one_rem_change_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(remote_bits ^ $past(remote_bits)) <= 1);

endmodule

bind pin_req_tracker pin_req_tracker_chk #(.NPINS(NPINS), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/pin_req_tracker_tb.sv
`timescale 1ns/1ps
module pin_req_tracker_tb;

  localparam int N  = 24;
  localparam int VW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]    pin_raw = '0, cmask = '0, clvl = '0, cpol = '0;
  logic [VW-1:0]   cvec [N];
  logic [N*VW-1:0] cvec_flat;
  logic            tbl_wr = 1'b0, tbl_wr_lo = 1'b0, eoi_valid = 1'b0;
  logic [IW-1:0]   tbl_wr_idx = '0;
  logic [VW-1:0]   eoi_vec = '0;
  logic            dlv_valid;
  logic [IW-1:0]   dlv_pin;
  logic [VW-1:0]   dlv_vec;
  logic [N-1:0]    req_bits, remote_bits;

  always_comb
    for (int i = 0; i < N; i++) cvec_flat[i*VW +: VW] = cvec[i];

  pin_req_tracker #(.NPINS(N), .VEC_W(VW)) u_dut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .cfg_mask(cmask),
    .cfg_level(clvl), .cfg_pol(cpol), .cfg_vec(cvec_flat),
    .tbl_wr(tbl_wr), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_lo(tbl_wr_lo),
    .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .dlv_valid(dlv_valid),
    .dlv_pin(dlv_pin), .dlv_vec(dlv_vec), .req_bits(req_bits),
    .remote_bits(remote_bits)
  );

  int tests = 0, fails = 0, cyc = 0;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge.
  bit m_pin [N];
  bit m_seen[N];
  bit m_irr [N];
  bit m_rem [N];
  bit m_dv;
  int m_dp, m_dvec;

  function automatic bit m_eff(int i);
    return m_pin[i] ^ cpol[i];
  endfunction

  task automatic m_service(int i);
    if (!cmask[i]) begin
      m_dv = 1; m_dp = i; m_dvec = cvec[i];
      if (clvl[i]) m_rem[i] = 1;
    end
    if (!clvl[i]) m_irr[i] = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_pin[i] = 0; m_seen[i] = 0; m_irr[i] = 0; m_rem[i] = 0;
      end
      m_dv = 0; m_dp = 0; m_dvec = 0;
    end else begin
      int pick;
      m_dv = 0;
      pick = -1;
      if (tbl_wr) begin
        if (int'(tbl_wr_idx) < N) begin
          pick = int'(tbl_wr_idx);
          if (tbl_wr_lo) m_rem[pick] = 0;
          if (m_irr[pick]) m_service(pick);
        end
      end else if (eoi_valid) begin
        for (int i = 0; i < N && pick < 0; i++)
          if (cvec[i] == eoi_vec) pick = i;
        if (pick >= 0) begin
          m_rem[pick] = 0;
          if (!cmask[pick] && m_irr[pick]) begin
            m_dv = 1; m_dp = pick; m_dvec = cvec[pick];
          end
        end
      end else begin
        for (int i = 0; i < N && pick < 0; i++)
          if (m_eff(i) != m_seen[i]) pick = i;
        if (pick >= 0) begin
          m_seen[pick] = m_eff(pick);
          if (!m_eff(pick)) m_irr[pick] = 0;
          else begin
            bit was;
            was = m_irr[pick];
            m_irr[pick] = 1;
            if ((!clvl[pick] && !was) || !m_rem[pick]) m_service(pick);
          end
        end
      end
      for (int i = 0; i < N; i++) m_pin[i] = pin_raw[i];
    end
  end

  // Per-cycle comparison against the model (R11 for the delivery outputs).
  always @(negedge clk) begin
    if (!rst) begin
      chk("R11 model dlv_valid", int'(dlv_valid), int'(m_dv));
      if (m_dv) begin
        chk("R11 model dlv_pin", int'(dlv_pin), m_dp);
        chk("R11 model dlv_vec", int'(dlv_vec), m_dvec);
      end
      for (int i = 0; i < N; i++) begin
        if (req_bits[i] != m_irr[i])
          chk("R2 model req_bits", int'(req_bits[i]), int'(m_irr[i]));
        if (remote_bits[i] != m_rem[i])
          chk("R8 model remote_bits", int'(remote_bits[i]), int'(m_rem[i]));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_pulse(int idx, bit lo);
    tbl_wr = 1'b1; tbl_wr_idx = IW'(idx); tbl_wr_lo = lo;
    tick();
    tbl_wr = 1'b0; tbl_wr_lo = 1'b0;
  endtask

  task automatic eoi_pulse(int v);
    eoi_valid = 1'b1; eoi_vec = VW'(v);
    tick();
    eoi_valid = 1'b0;
  endtask

  logic [N-1:0] snap_req, snap_rem;

  initial begin
    for (int i = 0; i < N; i++) cvec[i] = VW'(8'h40 + i);
    clvl[3] = 1; clvl[12] = 1; cvec[12] = 8'h43;
    clvl[7] = 1; cmask[7] = 1; cmask[6] = 1; clvl[9] = 1;
    tick(3);
    rst = 1'b0;
    tick();
    chk("R1 req_bits", int'(req_bits), 0);
    chk("R1 remote_bits", int'(remote_bits), 0);
    chk("R1 dlv_valid", int'(dlv_valid), 0);

    pin_raw[3] = 1; tick(2);
    chk("R3 dlv_valid", int'(dlv_valid), 1);
    chk("R3 dlv_pin", int'(dlv_pin), 3);
    chk("R3 dlv_vec", int'(dlv_vec), 8'h43);
    chk("R3 req3", int'(req_bits[3]), 1);
    chk("R3 rem3", int'(remote_bits[3]), 1);
    tick();
    chk("R11 single pulse", int'(dlv_valid), 0);

    pin_raw[3] = 0; tick(2);
    chk("R2 req3 cleared", int'(req_bits[3]), 0);
    pin_raw[3] = 1; tick(2);
    chk("R4 req3 set", int'(req_bits[3]), 1);
    chk("R4 no dlv", int'(dlv_valid), 0);
    chk("R4 rem3 held", int'(remote_bits[3]), 1);

    pin_raw[12] = 1; tick(2);
    chk("R3 dlv pin12", int'(dlv_pin), 12);
    chk("R3 rem12", int'(remote_bits[12]), 1);
    tick();

    eoi_pulse(8'h43);
    chk("R8 redeliver", int'(dlv_valid), 1);
    chk("R8 redeliver pin", int'(dlv_pin), 3);
    chk("R8 rem3 cleared", int'(remote_bits[3]), 0);
    chk("R8 rem12 kept", int'(remote_bits[12]), 1);
    tick();
    chk("R8 rem3 stays clear", int'(remote_bits[3]), 0);

    snap_req = req_bits; snap_rem = remote_bits;
    eoi_pulse(8'hEE);
    chk("R9 no dlv", int'(dlv_valid), 0);
    chk("R9 req same", int'(req_bits), int'(snap_req));
    chk("R9 rem same", int'(remote_bits), int'(snap_rem));

    pin_raw[5] = 1; tick(2);
    chk("R5 edge dlv pin", int'(dlv_pin), 5);
    chk("R5 edge dlv", int'(dlv_valid), 1);
    chk("R5 edge req clear", int'(req_bits[5]), 0);
    pin_raw[6] = 1; tick(2);
    chk("R5 masked edge no dlv", int'(dlv_valid), 0);
    chk("R5 masked edge req clear", int'(req_bits[6]), 0);

    pin_raw[7] = 1; tick(2);
    chk("R6 masked no dlv", int'(dlv_valid), 0);
    chk("R6 masked req kept", int'(req_bits[7]), 1);
    chk("R6 masked rem", int'(remote_bits[7]), 0);

    cmask[7] = 0; wr_pulse(7, 1);
    chk("R7 write redeliver", int'(dlv_valid), 1);
    chk("R7 write pin", int'(dlv_pin), 7);
    chk("R7 write rem7", int'(remote_bits[7]), 1);
    tick();
    wr_pulse(7, 0);
    chk("R7 upper write redeliver", int'(dlv_valid), 1);
    chk("R7 upper write pin", int'(dlv_pin), 7);

    snap_req = req_bits; snap_rem = remote_bits;
    wr_pulse(30, 1);
    chk("R7 bad index no dlv", int'(dlv_valid), 0);
    chk("R7 bad index req", int'(req_bits), int'(snap_req));
    chk("R7 bad index rem", int'(remote_bits), int'(snap_rem));

    cpol[9] = 1; wr_pulse(9, 1);
    tick();
    chk("R2 polarity dlv pin", int'(dlv_pin), 9);
    chk("R2 polarity dlv", int'(dlv_valid), 1);
    chk("R2 polarity req9", int'(req_bits[9]), 1);
    pin_raw[9] = 1; tick(2);
    chk("R2 active-low release", int'(req_bits[9]), 0);

    pin_raw[13] = 1; pin_raw[14] = 1; tick(2);
    chk("R10 first pin13", int'(dlv_pin), 13);
    tick();
    chk("R10 then pin14", int'(dlv_pin), 14);
    chk("R10 then pin14 valid", int'(dlv_valid), 1);

    pin_raw[16] = 1; pin_raw[17] = 1; tick();
    eoi_pulse(8'h43);
    chk("R10 eoi first", int'(dlv_pin), 3);
    tick();
    chk("R10 pin16 next", int'(dlv_pin), 16);
    tick();
    chk("R10 pin17 last", int'(dlv_pin), 17);
    tick(3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule